// File: doc/BRIEF.md
# Byte-Writable Synchronous SRAM Core

This block is a synthesizable behavioural model of a single-port synchronous static memory whose word is 18 bits wide. The word is split into two 9-bit lanes. Each lane holds 8 data bits and 1 parity bit, and the parity bit is stored like any other bit. An address sequencer outside this block supplies a word address. Input registers capture that address, the write controls and the write data on the rising clock edge.

A write is either a whole-word write or a write to selected lanes only. The array is updated on the following edge from the registered data, so no external write pulse shaping is needed. A read loads a pipelined output register one edge after the address is captured.

The data output is tri-state style: a data bus plus a drive-enable. The drive-enable responds at once to the output-enable input and to the power-down input. Power-down places the core in standby independently of the clock: it blocks writes, stops the output from being driven and keeps the array contents. The array depth is set by the address-width parameter.

Top module: `bwsram_core`

## Requirements
- R1: After reset, the data bus is not driven (`dq_oe` low) until a selected read has completed.
- R2: A read presented before edge E1 places the addressed word on `dq_o` after edge E2, and `dq_oe` is high from E2 until the next edge when `oe` is high.
- R3: With `sel` and `wr_all` high, all 18 bits are written, whatever `byte_wr_en` and `lane_we` are.
- R4: With `wr_all` low and `byte_wr_en` high, only the lanes whose `lane_we` bit is set are written. `lane_we[0]` controls bits 8:0 and `lane_we[1]` controls bits 17:9.
- R5: `byte_wr_en` high with `lane_we` all zero and `wr_all` low is a read cycle, and the array is unchanged.
- R6: `lane_we` bits set while `byte_wr_en` and `wr_all` are low is a read cycle, and the array is unchanged.
- R7: `oe` gates the drive asynchronously. Dropping it releases the bus within the same clock period, and raising it again drives the bus again.
- R8: The bus is driven only when the cycle registered at the previous edge was a selected read. After a write cycle or an idle cycle, `dq_oe` is low.
- R9: Raising `pd` releases the bus at once, without waiting for a clock edge.
- R10: While `pd` is high no write takes effect. This includes a write captured on the edge just before `pd` rose. Array contents are kept across power-down.
- R11: With `sel` low, no write occurs even if write controls are asserted, and no read is started.
- R12: A write followed in the very next cycle by a read of the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd | input | 1 | Power-down, active high, independent of the clock |
| sel | input | 1 | Cycle select for this device |
| wr_all | input | 1 | Whole-word write enable |
| byte_wr_en | input | 1 | Lane-write enable, qualifies `lane_we` |
| lane_we | input | LANES (2) | Per-lane write strobes |
| addr | input | ADDR_W (10) | Word address from the sequencer |
| wdata | input | 18 | Write data, lane 1 in bits 17:9, lane 0 in bits 8:0 |
| oe | input | 1 | Output enable, asynchronous |
| dq_o | output | 18 | Read data register |
| dq_oe | output | 1 | Drive enable for `dq_o` |

## Verification
Two functions can fall in the same cycle. The first is the delayed array update of a write captured on one edge. The second is power-down, which may rise before the next edge. The bench captures a write, raises `pd` before the edge that would commit it, lowers `pd` again, and reads the address back. The write is judged correctly blocked only if the word from before the write is returned. A second collision is a write followed at once by a read of the same address, where the bench expects the new word.

// File: rtl/bwsram_pkg.sv
`timescale 1ns/1ps
package bwsram_pkg;
  localparam int LANE_BITS  = 9;
  localparam int LANE_COUNT = 2;
  localparam int ADDR_BITS  = 10;
endpackage

// File: rtl/bwsram_inreg.sv
`timescale 1ns/1ps
module bwsram_inreg #(
  parameter int ADDR_W = bwsram_pkg::ADDR_BITS,
  parameter int LANES  = bwsram_pkg::LANE_COUNT,
  parameter int LANE_W = bwsram_pkg::LANE_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pd,
  input  logic                      sel,
  input  logic                      wr_all,
  input  logic                      byte_wr_en,
  input  logic [LANES-1:0]          lane_we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [LANES*LANE_W-1:0]   wdata_q,
  output logic [LANES-1:0]          wmask_q,
  output logic                      rd_q
);
  logic [LANES-1:0] wmask_d;
  logic             rd_d;
  logic             load_en;

  // Decode the lane mask for this cycle; an empty mask on a selected cycle is a read.
  always_comb begin
    wmask_d = '0;
    rd_d    = 1'b0;
    if (sel && !pd) begin
      if (wr_all)          wmask_d = '1;
      else if (byte_wr_en) wmask_d = lane_we;
      rd_d = (wmask_d == '0);
    end
  end

  assign load_en = sel & ~pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmask_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      wmask_q <= wmask_d;
      rd_q    <= rd_d;
    end
  end

  // Datapath registers carry no reset; they are qualified by the control registers.
  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end
endmodule

// File: rtl/bwsram_array.sv
`timescale 1ns/1ps
module bwsram_array #(
  parameter int ADDR_W = bwsram_pkg::ADDR_BITS,
  parameter int LANES  = bwsram_pkg::LANE_COUNT,
  parameter int LANE_W = bwsram_pkg::LANE_BITS
) (
  input  logic                      clk,
  input  logic                      pd,
  input  logic [ADDR_W-1:0]         addr_q,
  input  logic [LANES*LANE_W-1:0]   wdata_q,
  input  logic [LANES-1:0]          wmask_q,
  input  logic                      rd_q,
  output logic [LANES*LANE_W-1:0]   rdata_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rd_en;
  assign rd_en = rd_q & ~pd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_lane;
    logic              wr_en;

    assign wr_en = wmask_q[g] & ~pd;

    // Self-timed write: committed one edge after capture, from registered data.
    always_ff @(posedge clk) begin
      if (wr_en) mem[addr_q] <= wdata_q[g*LANE_W +: LANE_W];
      if (rd_en) rd_lane     <= mem[addr_q];
    end

    assign rdata_q[g*LANE_W +: LANE_W] = rd_lane;
  end
endmodule

// File: rtl/bwsram_outstage.sv
`timescale 1ns/1ps
module bwsram_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  input  logic oe,
  input  logic rd_q,
  output logic dq_oe
);
  logic rd_valid_q;
  logic rd_valid_d;

  assign rd_valid_d = rd_q & ~pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_valid_d;
  end

  // Output enable and power-down act without a clock edge.
  assign dq_oe = oe & ~pd & rd_valid_q;
endmodule

// File: rtl/bwsram_core.sv
`timescale 1ns/1ps
module bwsram_core #(
  parameter int ADDR_W = bwsram_pkg::ADDR_BITS,
  parameter int LANES  = bwsram_pkg::LANE_COUNT,
  parameter int LANE_W = bwsram_pkg::LANE_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pd,
  input  logic                    sel,
  input  logic                    wr_all,
  input  logic                    byte_wr_en,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);
  localparam int WORD_W = LANES * LANE_W;

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [LANES-1:0]  wmask_q;
  logic              rd_q;

  // Reset asserts asynchronously and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bwsram_inreg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_inreg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pd        (pd),
    .sel       (sel),
    .wr_all    (wr_all),
    .byte_wr_en(byte_wr_en),
    .lane_we   (lane_we),
    .addr      (addr),
    .wdata     (wdata),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .wmask_q   (wmask_q),
    .rd_q      (rd_q)
  );

  bwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk    (clk),
    .pd     (pd),
    .addr_q (addr_q),
    .wdata_q(wdata_q),
    .wmask_q(wmask_q),
    .rd_q   (rd_q),
    .rdata_q(dq_o)
  );

  bwsram_outstage i_out (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .pd   (pd),
    .oe   (oe),
    .rd_q (rd_q),
    .dq_oe(dq_oe)
  );
endmodule

// File: rtl/bwsram_core_chk.sv
`timescale 1ns/1ps
module bwsram_core_chk #(
  parameter int LANES = bwsram_pkg::LANE_COUNT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd,
  input logic             sel,
  input logic             wr_all,
  input logic             byte_wr_en,
  input logic [LANES-1:0] lane_we,
  input logic             oe,
  input logic             dq_oe
);
  logic [1:0] cyc_q;
  logic       rd_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  assign rd_cmd = sel & ~pd & ~(wr_all | (byte_wr_en & (|lane_we)));

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd0) |-> !dq_oe);

  // R8
  drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd2 && dq_oe) |-> ($past(rd_cmd, 2) && !$past(pd)));

  // R11
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd2 && !$past(sel, 2)) |-> !dq_oe);

  // R9
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> !dq_oe);

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_oe);
endmodule

bind bwsram_core bwsram_core_chk #(.LANES(LANES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pd        (pd),
  .sel       (sel),
  .wr_all    (wr_all),
  .byte_wr_en(byte_wr_en),
  .lane_we   (lane_we),
  .oe        (oe),
  .dq_oe     (dq_oe)
);

// File: tb/test_bwsram_core.sv
`timescale 1ns/1ps
module test_bwsram_core;
  logic        clk;
  logic        rst_n;
  logic        pd;
  logic        sel;
  logic        wr_all;
  logic        byte_wr_en;
  logic [1:0]  lane_we;
  logic [9:0]  addr;
  logic [17:0] wdata;
  logic        oe;
  logic [17:0] dq_o;
  logic        dq_oe;
  logic [17:0] dq_bus;
  int          total;
  int          bad;

  bwsram_core i_bwsram_core (
    .clk(clk), .rst_n(rst_n), .pd(pd), .sel(sel), .wr_all(wr_all),
    .byte_wr_en(byte_wr_en), .lane_we(lane_we), .addr(addr), .wdata(wdata),
    .oe(oe), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  assign dq_bus = dq_oe ? dq_o : 'z;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic wa, input logic bw,
                       input logic [1:0] lw, input logic [9:0] a, input logic [17:0] d);
    @(negedge clk);
    sel = s; wr_all = wa; byte_wr_en = bw; lane_we = lw; addr = a; wdata = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 2'b00, 10'd0, 18'd0);
  endtask

  // Read, then sample just after the second edge.
  task automatic rd_check(input string req, input logic [9:0] a, input logic [17:0] exp);
    drive(1'b1, 1'b0, 1'b0, 2'b00, a, 18'h15555);
    idle();
    @(posedge clk); #1;
    chk(req, {17'd0, dq_oe}, 18'd1);
    chk(req, dq_bus, exp);
  endtask

  task automatic t_reset();
    // R1
    #1;
    chk("R1", {17'd0, dq_oe}, 18'd0);
    chk("R1", dq_bus, 18'hzzzzz);
  endtask

  task automatic t_full_write();
    // R3: global write ignores lane controls
    drive(1'b1, 1'b1, 1'b1, 2'b01, 10'd5, 18'h2A5A5);
    idle();
    rd_check("R3", 10'd5, 18'h2A5A5);
    // R2: distinct address, distinct pattern
    drive(1'b1, 1'b1, 1'b0, 2'b00, 10'd6, 18'h13C3C);
    idle();
    rd_check("R2", 10'd6, 18'h13C3C);
  endtask

  task automatic t_lane_write();
    // R4: upper lane only
    drive(1'b1, 1'b0, 1'b1, 2'b10, 10'd5, 18'h3FFFF);
    idle();
    rd_check("R4", 10'd5, {9'h1FF, 9'h1A5});
    // R4: lower lane only
    drive(1'b1, 1'b0, 1'b1, 2'b01, 10'd5, 18'h00000);
    idle();
    rd_check("R4", 10'd5, {9'h1FF, 9'h000});
  endtask

  task automatic t_no_strobe();
    // R5: lane-write enable without strobes is a read
    drive(1'b1, 1'b0, 1'b1, 2'b00, 10'd6, 18'h00000);
    idle();
    @(posedge clk); #1;
    chk("R5", {17'd0, dq_oe}, 18'd1);
    chk("R5", dq_bus, 18'h13C3C);
    // R6: strobes without lane-write enable are a read
    drive(1'b1, 1'b0, 1'b0, 2'b11, 10'd6, 18'h00000);
    idle();
    @(posedge clk); #1;
    chk("R6", dq_bus, 18'h13C3C);
    rd_check("R6", 10'd6, 18'h13C3C);
  endtask

  task automatic t_oe();
    // R7
    drive(1'b1, 1'b0, 1'b0, 2'b00, 10'd6, 18'd0);
    idle();
    @(posedge clk); #1;
    oe = 1'b0; #0.5;
    chk("R7", {17'd0, dq_oe}, 18'd0);
    oe = 1'b1; #0.5;
    chk("R7", {17'd0, dq_oe}, 18'd1);
    chk("R7", dq_bus, 18'h13C3C);
  endtask

  task automatic t_after_write();
    // R8
    drive(1'b1, 1'b1, 1'b0, 2'b00, 10'd8, 18'h0F0F0);
    idle();
    @(posedge clk); #1;
    chk("R8", {17'd0, dq_oe}, 18'd0);
    @(posedge clk); #1;
    chk("R8", {17'd0, dq_oe}, 18'd0);
  endtask

  task automatic t_pd();
    // R9: asynchronous release
    drive(1'b1, 1'b0, 1'b0, 2'b00, 10'd8, 18'd0);
    idle();
    @(posedge clk); #1;
    pd = 1'b1; #0.5;
    chk("R9", {17'd0, dq_oe}, 18'd0);
    chk("R9", dq_bus, 18'hzzzzz);
    @(negedge clk); pd = 1'b0;
    // R10: write captured, then power-down before commit edge
    drive(1'b1, 1'b1, 1'b0, 2'b00, 10'd8, 18'h11111);
    @(negedge clk);
    pd = 1'b1; sel = 1'b0; wr_all = 1'b0;
    @(negedge clk);
    // R10: write presented during power-down
    drive(1'b1, 1'b1, 1'b0, 2'b00, 10'd8, 18'h22222);
    idle();
    pd = 1'b0;
    rd_check("R10", 10'd8, 18'h0F0F0);
  endtask

  task automatic t_desel();
    // R11
    drive(1'b0, 1'b1, 1'b1, 2'b11, 10'd8, 18'h33333);
    idle();
    @(posedge clk); #1;
    chk("R11", {17'd0, dq_oe}, 18'd0);
    rd_check("R11", 10'd8, 18'h0F0F0);
  endtask

  task automatic t_b2b();
    // R12
    drive(1'b1, 1'b1, 1'b0, 2'b00, 10'd7, 18'h2C0DE);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 10'd7, 18'd0);
    idle();
    @(posedge clk); #1;
    chk("R12", {17'd0, dq_oe}, 18'd1);
    chk("R12", dq_bus, 18'h2C0DE);
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; pd = 1'b0; sel = 1'b0; wr_all = 1'b0; byte_wr_en = 1'b0;
    lane_we = 2'b00; addr = '0; wdata = '0; oe = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_write();
    t_lane_write();
    t_no_strobe();
    t_oe();
    t_after_write();
    t_pd();
    t_desel();
    t_b2b();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule